// File: doc/BRIEF.md
# Wide-Bus Odd-Byte Residue Combiner

This block repacks a 16-bit receive data stream into properly paired output words when data moves are chained back to back. Each move is opened with a start pulse that carries a byte count, a chain-mode bit and a direction bit. The block then takes one inbound word per valid cycle until the count is used up. Every inbound word carries two bytes, except the final word of an odd-sized move, which carries one. The low lane is always the byte with the lower address.

A move can finish on an odd byte boundary. If it does so while chaining and receiving, the block keeps the leftover byte in a residue register instead of sending it on. That byte becomes the low lane of the first output word of the next move, and the rest of that move shifts over by one lane. In every other case an odd leftover byte goes out alone, marked as valid in the low lane only. A status flag reports whether a residue byte is being held.

Top module: `rcomb_top`

## Requirements
- R1: After reset, out_valid, busy and res_valid are all low.
- R2: With no residue held, each two-byte inbound word of a move appears one cycle later on out_data unchanged, with out_be = 2'b11 (bit 0 marks bits 7:0, bit 1 marks bits 15:8).
- R3: When a move ends on an odd boundary and does not keep a residue (chain bit clear, or direction bit clear meaning transmit), the last byte goes out with out_be = 2'b01 and out_data[15:8] = 0; the inbound upper byte is discarded.
- R4: When a move ends on an odd boundary with the chain bit and the receive bit both set, the last byte is not output, and res_valid is high once the move is over.
- R5: A held residue byte is output in bits 7:0 of the first word of the following move, with that move's first byte in bits 15:8; the move's remaining bytes follow, shifted by one lane.
- R6: If a residue is held and the next chained receive move has an even count, the residue is consumed and the final byte of that move becomes the new residue; res_valid stays high.
- R7: If a residue is held and the next move does not keep one, the byte left over at its end is output alone (out_be = 2'b01) one cycle after the last combined word, and res_valid then goes low.
- R8: move_start is ignored while busy, and in_valid is ignored while idle (no output results).
- R9: A move_start with a zero count leaves busy low.
- R10: busy rises one cycle after an accepted move_start and falls in the cycle after the last inbound word of the move is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| move_start | input | 1 | Opens a move; honoured only while idle |
| move_count | input | CNT_W | Byte count of the move |
| move_chain | input | 1 | Chain mode: allow a residue to be kept at the end |
| move_rx | input | 1 | 1 = receive, 0 = transmit |
| in_valid | input | 1 | Inbound word present |
| in_data | input | 2*LANE_W | Inbound word, low lane first in address order |
| out_valid | output | 1 | Output word present |
| out_data | output | 2*LANE_W | Output word |
| out_be | output | 2 | Per-lane byte valid of the output word |
| busy | output | 1 | Move in progress |
| res_valid | output | 1 | A residue byte is held |

## Verification
Two events can happen in one cycle: the held residue is consumed into a combined word, and a new residue is captured from the same inbound word. This occurs when the final word of an even-count chained receive move arrives while a residue is already held. The bench builds that situation by running an odd chained receive move followed by a two-byte chained receive move. It then checks that the combined word carries the old residue in its low lane, and that the flag stays set for the next move, whose first output word must then carry the new residue. A second overlap comes from a non-keeping move that leaves a byte behind. Its flush must follow the last combined word by exactly one cycle, and the bench checks this through the output word sequence and the residue flag.

// File: rtl/rcomb_pkg.sv
package rcomb_pkg;

  // per-lane byte-valid codes on the output
  localparam logic [1:0] BE_LO   = 2'b01;
  localparam logic [1:0] BE_BOTH = 2'b11;

  // two bytes can be taken from the current word
  function automatic logic f_take_two(input logic [31:0] remaining);
    return remaining >= 32'd2;
  endfunction

  // the current word is the final word of the move
  function automatic logic f_is_last(input logic [31:0] remaining);
    return remaining <= 32'd2;
  endfunction

  // a leftover byte may be parked across the move boundary
  function automatic logic f_keep(input logic chain, input logic rx);
    return chain & rx;
  endfunction

endpackage

// File: rtl/rcomb_tracker.sv
module rcomb_tracker
  import rcomb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             move_start,
  input  logic [CNT_W-1:0] move_count,
  input  logic             move_chain,
  input  logic             move_rx,
  input  logic             in_valid,
  output logic             busy,
  output logic             accept,
  output logic             take_two,
  output logic             last_word,
  output logic             keep
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] rem;
  logic             start_ok;

  assign start_ok  = move_start & ~busy & (move_count != '0);
  assign accept    = busy & in_valid;
  assign take_two  = f_take_two(32'(rem));
  assign last_word = f_is_last(32'(rem));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem  <= '0;
      busy <= 1'b0;
      keep <= 1'b0;
    end else if (start_ok) begin
      rem  <= move_count;
      busy <= 1'b1;
      keep <= f_keep(move_chain, move_rx);
    end else if (accept) begin
      rem  <= rem - (take_two ? TWO : ONE);
      busy <= ~last_word;
    end
  end

  // R10: the last word closes the move
  p_busy_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept && last_word |=> !busy);

  // R8: a start pulse during a move changes nothing
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && move_start && !in_valid |=> busy && $stable(rem));

  // R9: zero-length move never opens
  p_zero_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && move_start && move_count == '0 |=> !busy);

endmodule

// File: rtl/rcomb_packer.sv
module rcomb_packer
  import rcomb_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                take_two,
  input  logic                last_word,
  input  logic                keep,
  input  logic [2*LANE_W-1:0] in_data,
  output logic                out_valid,
  output logic [2*LANE_W-1:0] out_data,
  output logic [1:0]          out_be,
  output logic                res_valid
);
  localparam int WORD_W = 2 * LANE_W;

  logic [LANE_W-1:0] hold;
  logic              hv;
  logic              flush_pend;
  logic [LANE_W-1:0] lo_b, hi_b;

  // named events for the checks
  logic ev_save, ev_consume, ev_flush;

  assign lo_b       = in_data[LANE_W-1:0];
  assign hi_b       = in_data[WORD_W-1:LANE_W];
  assign ev_save    = accept & ~hv & ~take_two & keep;
  assign ev_consume = accept & hv;
  assign ev_flush   = flush_pend;
  assign res_valid  = hv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold       <= '0;
      hv         <= 1'b0;
      flush_pend <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_be     <= '0;
    end else begin
      out_valid <= 1'b0;
      if (ev_flush) begin
        out_valid  <= 1'b1;
        out_data   <= {{LANE_W{1'b0}}, hold};
        out_be     <= BE_LO;
        hv         <= 1'b0;
        flush_pend <= 1'b0;
      end else if (accept) begin
        if (!hv) begin
          if (take_two) begin
            out_valid <= 1'b1;
            out_data  <= in_data;
            out_be    <= BE_BOTH;
          end else if (keep) begin
            hold <= lo_b;
            hv   <= 1'b1;
          end else begin
            out_valid <= 1'b1;
            out_data  <= {{LANE_W{1'b0}}, lo_b};
            out_be    <= BE_LO;
          end
        end else begin
          out_valid <= 1'b1;
          out_data  <= {lo_b, hold};
          out_be    <= BE_BOTH;
          if (take_two) begin
            hold <= hi_b;
            if (last_word && !keep) flush_pend <= 1'b1;
          end else begin
            hv <= 1'b0;
          end
        end
      end
    end
  end

  // R4: a parked byte produces no output
  p_save_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_save |=> !out_valid && hv);

  // R5: residue lands in the low lane of a full word
  p_consume_pairs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_consume |=> out_valid && out_be == BE_BOTH
                   && out_data[LANE_W-1:0] == $past(hold));

  // R7: flush is a lone low byte and clears the flag
  p_flush_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush |=> out_valid && out_be == BE_LO && !hv);

  // R3: a lone byte carries a zero upper lane
  p_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_be == BE_LO |-> out_data[WORD_W-1:LANE_W] == '0);

  // R8: no input and no flush means no output
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept && !ev_flush |=> !out_valid);

endmodule

// File: rtl/rcomb_top.sv
module rcomb_top
  import rcomb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                move_start,
  input  logic [CNT_W-1:0]    move_count,
  input  logic                move_chain,
  input  logic                move_rx,
  input  logic                in_valid,
  input  logic [2*LANE_W-1:0] in_data,
  output logic                out_valid,
  output logic [2*LANE_W-1:0] out_data,
  output logic [1:0]          out_be,
  output logic                busy,
  output logic                res_valid
);
  logic accept, take_two, last_word, keep;

  rcomb_tracker #(.CNT_W(CNT_W)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .move_start (move_start),
    .move_count (move_count),
    .move_chain (move_chain),
    .move_rx    (move_rx),
    .in_valid   (in_valid),
    .busy       (busy),
    .accept     (accept),
    .take_two   (take_two),
    .last_word  (last_word),
    .keep       (keep)
  );

  rcomb_packer #(.LANE_W(LANE_W)) u_pck (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .take_two   (take_two),
    .last_word  (last_word),
    .keep       (keep),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_be     (out_be),
    .res_valid  (res_valid)
  );

  // R1: idle outputs right after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !busy && !res_valid);

endmodule

// File: tb/rcomb_top_test.sv
`timescale 1ns/1ps
module rcomb_top_test;
  localparam int CNT_W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        move_start = 1'b0;
  logic [15:0] move_count = '0;
  logic        move_chain = 1'b0;
  logic        move_rx = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_data;
  logic [1:0]  out_be;
  logic        busy;
  logic        res_valid;

  always #10 clk = ~clk;

  rcomb_top #(.CNT_W(CNT_W), .LANE_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .move_start(move_start), .move_count(move_count),
    .move_chain(move_chain), .move_rx(move_rx), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_be(out_be), .busy(busy), .res_valid(res_valid)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // captured output words
  logic [15:0] cap_d [0:31];
  logic [1:0]  cap_b [0:31];
  int          n_out = 0;

  always @(negedge clk) begin
    if (rst_n && out_valid && n_out < 32) begin
      cap_d[n_out] = out_data;
      cap_b[n_out] = out_be;
      n_out = n_out + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // bench model of the held byte
  logic [7:0] mres = '0;
  bit         mres_v = 0;

  // stimulus table: {count[3:0], chain, rx, seed_hi[3:0]}
  localparam int NV = 9;
  localparam logic [9:0] VEC [0:NV-1] = '{
    {4'd4, 1'b0, 1'b1, 4'h1},
    {4'd3, 1'b0, 1'b1, 4'h2},
    {4'd5, 1'b1, 1'b0, 4'h3},
    {4'd3, 1'b1, 1'b1, 4'h4},
    {4'd2, 1'b1, 1'b1, 4'h5},
    {4'd3, 1'b1, 1'b1, 4'h6},
    {4'd1, 1'b1, 1'b1, 4'h7},
    {4'd4, 1'b0, 1'b1, 4'h8},
    {4'd6, 1'b0, 1'b1, 4'h9}
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2: return "R3";
      3: return "R4";
      4: return "R6";
      5: return "R5";
      6: return "R4";
      7: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic run_move(input int c, input bit ch, input bit rx,
                          input logic [7:0] seed, input string tag);
    logic [7:0]  s [0:17];
    logic [15:0] ed [0:15];
    logic [1:0]  eb [0:15];
    int n = 0;
    int ne = 0;
    int k = 0;
    if (mres_v) begin s[n] = mres; n++; end
    for (int i = 0; i < c; i++) begin s[n] = 8'(seed + i); n++; end
    while (k + 1 < n) begin
      ed[ne] = {s[k+1], s[k]}; eb[ne] = 2'b11; ne++; k += 2;
    end
    if (k < n) begin
      if (ch && rx) begin mres = s[k]; mres_v = 1; end
      else begin ed[ne] = {8'h00, s[k]}; eb[ne] = 2'b01; ne++; mres_v = 0; end
    end else begin
      mres_v = 0;
    end

    @(negedge clk);
    n_out = 0;
    move_start = 1; move_count = 16'(c); move_chain = ch; move_rx = rx;
    @(negedge clk);
    move_start = 0;
    chk(busy == 1'b1, "R10", "busy after start", int'(busy), 1);
    for (int j = 0; j < (c + 1) / 2; j++) begin
      in_valid = 1;
      in_data = {(2*j + 1 < c) ? 8'(seed + 2*j + 1) : 8'hEE, 8'(seed + 2*j)};
      @(negedge clk);
    end
    in_valid = 0;
    chk(busy == 1'b0, "R10", "busy after last word", int'(busy), 0);
    repeat (3) @(negedge clk);
    chk(n_out == ne, tag, "word count", n_out, ne);
    for (int w = 0; w < ne && w < n_out; w++) begin
      chk(cap_d[w] == ed[w], tag, "word data", int'(cap_d[w]), int'(ed[w]));
      chk(cap_b[w] == eb[w], tag, "byte valid", int'(cap_b[w]), int'(eb[w]));
    end
    chk(res_valid == mres_v, tag, "residue flag", int'(res_valid), int'(mres_v));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(busy == 0, "R1", "busy in reset", int'(busy), 0);
    chk(res_valid == 0, "R1", "res_valid in reset", int'(res_valid), 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_move(int'(VEC[i][9:6]), VEC[i][5], VEC[i][4],
               {VEC[i][3:0], 4'h0}, tag_of(i));
    end

    // R8: in_valid while idle gives nothing
    n_out = 0;
    in_valid = 1; in_data = 16'hBEEF;
    repeat (2) @(negedge clk);
    in_valid = 0;
    repeat (2) @(negedge clk);
    chk(n_out == 0, "R8", "output while idle", n_out, 0);
    chk(busy == 0, "R8", "busy while idle input", int'(busy), 0);

    // R9: zero count never opens a move
    move_start = 1; move_count = 16'd0; move_chain = 0; move_rx = 1;
    @(negedge clk);
    move_start = 0;
    chk(busy == 0, "R9", "busy after zero count", int'(busy), 0);

    // R8: a start pulse during a move is ignored
    n_out = 0;
    move_start = 1; move_count = 16'd4;
    @(negedge clk);
    move_start = 0;
    in_valid = 1; in_data = 16'h2211;
    @(negedge clk);
    in_valid = 0;
    move_start = 1; move_count = 16'd8;
    @(negedge clk);
    move_start = 0;
    chk(busy == 1, "R8", "busy kept mid move", int'(busy), 1);
    in_valid = 1; in_data = 16'h4433;
    @(negedge clk);
    in_valid = 0;
    chk(busy == 0, "R8", "original count honoured", int'(busy), 0);
    repeat (2) @(negedge clk);
    chk(n_out == 2, "R8", "words of ignored-start move", n_out, 2);
    if (n_out >= 2)
      chk(cap_d[1] == 16'h4433, "R2", "second word", int'(cap_d[1]), 'h4433);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule